// File: doc/BRIEF.md
# Page Write Collector with Write-Cycle Timer

This block sits between a serial-bus controller and a byte-wide storage array of 16 pages with 16 bytes each. While a write transaction is under way, the controller first hands over a start address. It then hands over data bytes one at a time. The block keeps these bytes in a one-page staging buffer and records which columns of the page have been filled.

When the transaction ends with a stop, the block copies the filled columns into the array through a simple write port. It then reports busy for a fixed number of clock cycles to model the array's programming time. An abort strobe drops the staged bytes without writing anything. Abort covers a repeated start before the stop, and a data byte that the controller rejected.

The column pointer stays inside the selected page. Bytes beyond sixteen wrap back to column 0 and overwrite what was staged there. The length of the write cycle is a parameter given in clock cycles. The default of 1,250,000 cycles gives 5 ms at 250 MHz.

Top module: `pgwr_buffer`

## Requirements
- R1: After reset `busy` and `arrWe` are low, and no array write happens until a stop commits staged bytes.
- R2: A `loadAddr` strobe takes `addrIn[7:4]` as the page and `addrIn[3:0]` as the starting column, and it discards any bytes already staged.
- R3: Each `pushByte` strobe stages `dataIn` at the current column, then advances the column by one.
- R4: The column wraps from 15 to 0 inside the same page. A later byte for a column replaces the earlier one, so one commit writes at most 16 bytes.
- R5: A stop with at least one staged byte starts a 16-cycle scan in the cycle after the strobe is sampled. In scan cycle k (k = 0..15), `arrWe` is high exactly when column k was staged, with `arrAddr` = {page, k} and `arrData` = the last byte staged there. Columns that were not staged are never written.
- R6: A stop with nothing staged writes nothing and leaves `busy` low.
- R7: An `abortStrobe` discards the staged bytes, writes nothing and leaves `busy` low. A stop that follows it writes nothing.
- R8: `busy` rises in the cycle after a committing stop is sampled. It stays high for exactly 16 + WRITE_CYCLES cycles and then falls.
- R9: While `busy` is high, all four controller strobes are ignored. Pushes and stops made during that time produce no writes.
- R10: When several strobes arrive in one cycle, only the highest-priority one acts. The order from highest to lowest is abort, stop, load, push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadAddr | input | 1 | Strobe: take start address |
| addrIn | input | 8 | Start address: page in [7:4], column in [3:0] |
| pushByte | input | 1 | Strobe: stage one data byte |
| dataIn | input | 8 | Data byte to stage |
| stopStrobe | input | 1 | Strobe: end of write transaction, commit |
| abortStrobe | input | 1 | Strobe: discard staged bytes |
| busy | output | 1 | Commit scan or write-cycle timer running |
| arrWe | output | 1 | Array write enable, one byte per cycle |
| arrAddr | output | 8 | Array byte address {page, column} |
| arrData | output | 8 | Array write data |

## Verification
The bench drives several kinds of transaction:
- A single byte in the middle of a page shows that only that column is written.
- A short burst that starts at column 14 and crosses the page end shows the in-page wrap and the ascending write order.
- Twenty bytes from column 0 show that later bytes replace earlier ones and that at most 16 writes occur.
- Aborted and empty transactions, along with strobes sent during busy, must produce no write and no busy pulse.
- Strobe collisions in a single cycle separate each priority pair.

Every write is compared, in order, against the scoreboard queue. Every busy window is counted against 16 + WRITE_CYCLES.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clearMask;  // drop all staged columns
    logic loadPtr;    // take page and column from addrIn
    logic pushWr;     // stage dataIn at current column
    logic scanStart;  // reset the commit scan column
    logic scanStep;   // advance the commit scan column
    logic scanOn;     // commit scan in progress
  } pgwrCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_TIMER = 2'd2
  } pgwrState_t;

endpackage

// File: rtl/pgwr_datapath.sv
module pgwr_datapath
  import pgwr_pkg::*;
#(
  parameter int PAGE_BITS = 4,
  parameter int COL_BITS  = 4,
  parameter int DATA_W    = 8,
  localparam int NCOL     = 1 << COL_BITS,
  localparam int ADDR_W   = PAGE_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgwrCtl_t          ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              maskAny,
  output logic              scanLast,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);

  logic [PAGE_BITS-1:0] pageReg;
  logic [COL_BITS-1:0]  colReg;
  logic [COL_BITS-1:0]  scanCol;
  logic [NCOL-1:0]      validMask;
  logic [NCOL-1:0]      colHit;
  logic [DATA_W-1:0]    bufMem [NCOL];

  // Per-column write select for the staging buffer
  for (genvar g = 0; g < NCOL; g++) begin : gColSel
    assign colHit[g] = ctl.pushWr && (colReg == COL_BITS'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCOL; i++) begin
      if (colHit[i]) bufMem[i] <= dataIn;
    end
  end

  // Page / column pointer, valid mask, scan column
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg   <= '0;
      colReg    <= '0;
      validMask <= '0;
      scanCol   <= '0;
    end else begin
      if (ctl.loadPtr) begin
        pageReg <= addrIn[ADDR_W-1:COL_BITS];
        colReg  <= addrIn[COL_BITS-1:0];
      end else if (ctl.pushWr) begin
        colReg  <= colReg + 1'b1;
      end

      if (ctl.clearMask || ctl.loadPtr) begin
        validMask <= '0;
      end else if (ctl.pushWr) begin
        validMask <= validMask | colHit;
      end

      if (ctl.scanStart) begin
        scanCol <= '0;
      end else if (ctl.scanStep) begin
        scanCol <= scanCol + 1'b1;
      end
    end
  end

  assign maskAny  = |validMask;
  assign scanLast = &scanCol;
  assign arrWe    = ctl.scanOn && validMask[scanCol];
  assign arrAddr  = {pageReg, scanCol};
  assign arrData  = bufMem[scanCol];

  // R3: column steps by one per staged byte
  a_r3_col_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pushWr && !ctl.loadPtr) |=> colReg == COL_BITS'($past(colReg) + 1'b1));

  // R4: the last column wraps to column 0 and the page is unchanged
  a_r4_col_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pushWr && !ctl.loadPtr && (&colReg)) |=> (colReg == '0) && $stable(pageReg));

  // R7: discarding leaves no staged column
  a_r7_mask_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clearMask && !ctl.pushWr) |=> !maskAny);

endmodule

// File: rtl/pgwr_control.sv
module pgwr_control
  import pgwr_pkg::*;
#(
  parameter int WRITE_CYCLES = 1250000,
  localparam int TW          = $clog2(WRITE_CYCLES + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     loadAddr,
  input  logic     pushByte,
  input  logic     stopStrobe,
  input  logic     abortStrobe,
  input  logic     maskAny,
  input  logic     scanLast,
  output pgwrCtl_t ctl,
  output logic     busy
);

  pgwrState_t    state;
  logic [TW-1:0] timerCnt;
  logic          commitGo;

  assign commitGo = (state == ST_IDLE) && !abortStrobe && stopStrobe && maskAny;

  // Strobe decode: abort > stop > load > push, all only while idle
  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE: begin
        if (abortStrobe)     ctl.clearMask = 1'b1;
        else if (stopStrobe) begin
          if (maskAny) ctl.scanStart = 1'b1;
          else         ctl.clearMask = 1'b1;
        end
        else if (loadAddr)   ctl.loadPtr   = 1'b1;
        else if (pushByte)   ctl.pushWr    = 1'b1;
      end
      ST_SCAN: begin
        ctl.scanOn   = 1'b1;
        ctl.scanStep = 1'b1;
        if (scanLast) ctl.clearMask = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timerCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (commitGo) state <= ST_SCAN;
        ST_SCAN: if (scanLast) begin
          state    <= ST_TIMER;
          timerCnt <= '0;
        end
        ST_TIMER: begin
          if (timerCnt == TW'(WRITE_CYCLES - 1)) state <= ST_IDLE;
          else timerCnt <= timerCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R8: timer never runs past the programmed length
  a_r8_timer_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TIMER) |-> timerCnt < TW'(WRITE_CYCLES));

  // R6: an empty stop does not start a write cycle
  a_r6_empty_stop: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && stopStrobe && !abortStrobe && !maskAny) |=> !busy);

  // R8: busy rises right after a committing stop
  a_r8_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    commitGo |=> busy);

endmodule

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
  parameter int PAGE_BITS    = 4,
  parameter int COL_BITS     = 4,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 1250000,
  localparam int ADDR_W      = PAGE_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadAddr,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              pushByte,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              stopStrobe,
  input  logic              abortStrobe,
  output logic              busy,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);

  pgwr_pkg::pgwrCtl_t ctl;
  logic maskAny;
  logic scanLast;

  pgwr_control #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .loadAddr(loadAddr), .pushByte(pushByte),
    .stopStrobe(stopStrobe), .abortStrobe(abortStrobe),
    .maskAny(maskAny), .scanLast(scanLast),
    .ctl(ctl), .busy(busy)
  );

  pgwr_datapath #(.PAGE_BITS(PAGE_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .addrIn(addrIn), .dataIn(dataIn),
    .maskAny(maskAny), .scanLast(scanLast),
    .arrWe(arrWe), .arrAddr(arrAddr), .arrData(arrData)
  );

  // R5: array writes happen only inside a busy window
  a_r5_we_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> busy);

  // R9: busy never falls while a write is being issued
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |=> busy);

endmodule

// File: tb/pgwr_buffer_tb_top.sv
module pgwr_buffer_tb_top;

  localparam int WC = 40;
  localparam int BUSY_LEN = 16 + WC;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadAddr = 0, pushByte = 0, stopStrobe = 0, abortStrobe = 0;
  logic [7:0] addrIn = '0, dataIn = '0;
  logic       busy, arrWe;
  logic [7:0] arrAddr, arrData;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] expQ[$];

  // requirement-level model of staged state
  logic [3:0] mPage = 0, mCol = 0;
  logic [15:0] mMask = 0;
  logic [7:0] mBuf [16];

  always #2 clk = ~clk;  // 250 MHz

  pgwr_buffer #(.WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rstN(rstN), .loadAddr(loadAddr), .addrIn(addrIn),
    .pushByte(pushByte), .dataIn(dataIn), .stopStrobe(stopStrobe),
    .abortStrobe(abortStrobe), .busy(busy), .arrWe(arrWe),
    .arrAddr(arrAddr), .arrData(arrData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare each array write (R5)
  always @(negedge clk) begin
    if (rstN && arrWe) begin
      if (expQ.size() == 0) begin
        check(0, "R5 unexpected write", {arrAddr, arrData}, 0);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        check({arrAddr, arrData} == e, "R5 write addr/data", {arrAddr, arrData}, e);
      end
    end
  end

  // driver: one cycle of strobes, model updated by priority (R10)
  task automatic drive(input bit ab, input bit st, input bit ld, input bit ps,
                       input logic [7:0] a, input logic [7:0] d, input bit idle);
    @(negedge clk);
    abortStrobe = ab; stopStrobe = st; loadAddr = ld; pushByte = ps;
    addrIn = a; dataIn = d;
    if (idle) begin
      if (ab) mMask = 0;
      else if (st) begin
        for (int c = 0; c < 16; c++)
          if (mMask[c]) expQ.push_back({mPage, 4'(c), mBuf[c]});
        mMask = 0;
      end else if (ld) begin
        mPage = a[7:4]; mCol = a[3:0]; mMask = 0;
      end else if (ps) begin
        mBuf[mCol] = d; mMask[mCol] = 1'b1; mCol = mCol + 1'b1;
      end
    end
    @(negedge clk);
    abortStrobe = 0; stopStrobe = 0; loadAddr = 0; pushByte = 0;
  endtask

  task automatic doLoad(input logic [7:0] a); drive(0, 0, 1, 0, a, 0, 1); endtask
  task automatic doPush(input logic [7:0] d); drive(0, 0, 0, 1, 0, d, 1); endtask
  task automatic doAbort(); drive(1, 0, 0, 0, 0, 0, 1); endtask

  // stop, then measure busy window (R8) and drain check (R5)
  task automatic doStop(input bit expCommit, input string req);
    int n;
    drive(0, 1, 0, 0, 0, 0, 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == (expCommit ? BUSY_LEN : 0), {req, " busy length R8"}, n, expCommit ? BUSY_LEN : 0);
    check(expQ.size() == 0, {req, " all writes seen"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && arrWe == 0, "R1 reset outputs", {busy, arrWe}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && arrWe == 0, "R1 idle after reset", {busy, arrWe}, 0);

    // single byte mid-page (R2, R3, R5)
    doLoad(8'h37); doPush(8'hA5);
    doStop(1, "R2 single byte");

    // burst crossing column 15 wraps in page (R4)
    doLoad(8'h5E);
    for (int i = 0; i < 5; i++) doPush(8'h10 + 8'(i));
    doStop(1, "R4 wrap burst");

    // 20 bytes: overwrite, at most 16 writes (R4, R3)
    doLoad(8'hC0);
    for (int i = 0; i < 20; i++) doPush(8'(i * 7 + 1));
    doStop(1, "R4 overflow 20 bytes");

    // empty stop (R6)
    doStop(0, "R6 empty stop");

    // abort then stop (R7)
    doLoad(8'h21); doPush(8'h44); doPush(8'h55);
    doAbort();
    check(busy == 0, "R7 busy after abort", busy, 0);
    doStop(0, "R7 stop after abort");

    // reload discards staged bytes (R2)
    doLoad(8'h80); doPush(8'h11); doLoad(8'h93); doPush(8'h22);
    doStop(1, "R2 reload discards");

    // strobes during busy ignored (R9)
    doLoad(8'h40); doPush(8'h66);
    drive(0, 1, 0, 0, 0, 0, 1);
    repeat (3) drive(0, 0, 0, 1, 0, 8'hEE, 0);
    drive(0, 0, 1, 0, 8'hF0, 0, 0);
    drive(0, 1, 0, 0, 0, 0, 0);
    while (busy) @(negedge clk);
    check(expQ.size() == 0, "R9 busy-window writes", expQ.size(), 0);
    doStop(0, "R9 pushes in busy ignored");

    // priority collisions (R10)
    doLoad(8'h12); doPush(8'h77);
    drive(1, 1, 0, 0, 0, 0, 1);       // abort beats stop
    check(busy == 0, "R10 abort over stop", busy, 0);
    doStop(0, "R10 abort over stop");
    doLoad(8'h34); doPush(8'h88);
    drive(0, 1, 1, 0, 8'hF5, 0, 1);   // stop beats load: old page commits
    begin
      int n = 0;
      while (busy) begin n++; @(negedge clk); end
      check(n == BUSY_LEN, "R10 stop over load busy", n, BUSY_LEN);
      check(expQ.size() == 0, "R10 stop over load writes", expQ.size(), 0);
    end
    drive(0, 0, 1, 1, 8'h60, 8'h99, 1); // load beats push
    doStop(0, "R10 load over push");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule